// File: doc/BRIEF.md
# Prefix-Driven Vector Address Calculator

This block turns a stream of one-byte address prefixes into an effective address. Each byte carries two decimal digits, one per nibble. The first byte of a vector names the base register and supplies the first displacement digit. Every later byte appends one more displacement digit below the earlier ones. The same later byte also changes a running index sum in one of three ways:

- A register digit that has not been seen yet is added to the sum.
- A register digit that is already in the sum doubles the sum and then adds that register once more.
- The base digit only doubles the sum.

By repeating digits in the right order, any integer weight can be given to any index register.

Register values come in through a combinational read port. The port is addressed by the high nibble of the byte currently on the input. A terminating byte closes the vector. On that byte the block outputs, for one cycle, the sum of the base value, the index sum and the binary value of the decimal displacement. It then forgets the vector. For each prefix, a rotate strobe marks a doubling and a shift strobe marks an added register. The base register number is latched on its own output.

Top module: `prefix_vector_agu`

## Requirements
- R1: On the first accepted prefix of a vector (no vector open), the high digit becomes the base register and the low digit becomes the displacement. The base register value is captured from the read port in that same cycle. Neither strobe fires in the following cycle.
- R2: Every later prefix shifts the packed BCD displacement left by one nibble and puts its low digit in bits [3:0]. With the 32-bit default, digits beyond the eighth push the oldest digit out.
- R3: A later prefix whose high digit is neither the base nor already in the index sum adds that register value to the sum. In the next cycle, shift_o is 1 and rotate_o is 0.
- R4: A later prefix whose high digit is already in the index sum sets the sum to twice itself plus that register value. In the next cycle, both rotate_o and shift_o are 1.
- R5: A later prefix whose high digit equals the base register doubles the index sum. In the next cycle, rotate_o is 1 and shift_o is 0.
- R6: A terminating byte is 0x00, or any byte with a nibble above 9. When one is accepted while a vector is open, the next cycle shows addr_valid_o high for exactly one cycle. In that cycle, addr_o equals base value + index sum + binary displacement, modulo 2^AW, and disp_bcd_o holds the BCD displacement. The vector state is then cleared.
- R7: A terminating byte accepted while no vector is open produces no valid pulse and no strobe.
- R8: While en_n is high, the byte input has no effect on any output or on the vector state.
- R9: With en_n low and mode_n high, the open vector is abandoned with no valid pulse and no strobe. The next prefix starts a new vector.
- R10: base_idx_o takes the base digit only on a first prefix that is accepted while base_le_n is low. Otherwise it keeps its value.
- R11: After a synchronous reset, all outputs that have registers are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| mode_n | input | 1 | Low: build the vector; high: abandon it (when en_n is low) |
| en_n | input | 1 | Byte accept, active low |
| base_le_n | input | 1 | Base index output latch enable, active low |
| pfx_i | input | 8 | Prefix byte, two decimal digit nibbles |
| rd_idx_o | output | 4 | Register read address (high nibble of pfx_i) |
| rd_data_i | input | AW | Register value for rd_idx_o, same cycle |
| base_idx_o | output | 4 | Latched base register number |
| rotate_o | output | 1 | Index sum was doubled by the previous byte |
| shift_o | output | 1 | A register was added by the previous byte |
| addr_valid_o | output | 1 | One-cycle pulse: addr_o and disp_bcd_o are valid |
| addr_o | output | AW | Effective address |
| disp_bcd_o | output | DW | Displacement as packed BCD |

## Verification
A wrong set of used registers misclassifies the next repeated digit. That shows up one cycle later as a missing or extra rotate strobe, long before any address appears. An index sum that is off, or a lost base value, shows only at the valid pulse that follows the terminator. For this reason, every random vector ends in a terminator, and its address is checked against a bench model. A displacement that shifts wrongly is caught in the same cycle through disp_bcd_o, including vectors longer than eight digits.

// File: rtl/pva_pkg.sv
// Shared definitions for the prefix vector address calculator.
// Assumes digits 0..9 name registers; codes 10..15 are never register names.
package pva_pkg;
    localparam int NREG = 10;

    // Action a non-terminating prefix takes on the vector state.
    typedef enum logic [1:0] {
        ACT_FIRST   = 2'd0,
        ACT_ADD     = 2'd1,
        ACT_DBL_ADD = 2'd2,
        ACT_DBL     = 2'd3
    } pva_act_e;

    // A byte closes the vector when it is zero or has a non-decimal nibble.
    function automatic logic is_terminator(input logic [7:0] b);
        return (b == 8'h00) || (b[7:4] > 4'd9) || (b[3:0] > 4'd9);
    endfunction
endpackage

// File: rtl/pva_classify.sv
// Classifies the incoming byte: terminator or one of four prefix actions.
// Assumes used_i holds one bit per decimal register already in the index sum.
module pva_classify
    import pva_pkg::*;
(
    input  logic [7:0]      byte_i,
    input  logic            active_i,
    input  logic [3:0]      base_i,
    input  logic [NREG-1:0] used_i,
    output logic            term_o,
    output pva_act_e        act_o
);
    logic [3:0] hi;
    logic       seen;

    // Look up whether the named register is already in the sum.
    always_comb begin
        hi   = byte_i[7:4];
        seen = 1'b0;
        for (int i = 0; i < NREG; i++) begin
            if (hi == 4'(i)) seen = used_i[i];
        end
    end

    // Pick the action from the vector state and the high digit.
    always_comb begin
        term_o = is_terminator(byte_i);
        if (!active_i)        act_o = ACT_FIRST;
        else if (hi == base_i) act_o = ACT_DBL;
        else if (seen)         act_o = ACT_DBL_ADD;
        else                   act_o = ACT_ADD;
    end
endmodule

// File: rtl/pva_index_acc.sv
// Holds the weighted index sum and the set of registers used in it.
// Emits the rotate (doubled) and shift (added) strobes one cycle after a step.
// Assumes step_i and clear_i are never high together.
module pva_index_acc
    import pva_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            step_i,
    input  logic            clear_i,
    input  pva_act_e        act_i,
    input  logic [3:0]      hi_i,
    input  logic [AW-1:0]   rd_data_i,
    output logic [AW-1:0]   idx_o,
    output logic [NREG-1:0] used_o,
    output logic            rot_o,
    output logic            shf_o
);
    logic [NREG-1:0] hi_bit;

    // One-hot form of the register digit.
    always_comb begin
        hi_bit = '0;
        for (int i = 0; i < NREG; i++) hi_bit[i] = (hi_i == 4'(i));
    end

    // Update the index sum, the used set and the strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_o  <= '0;
            used_o <= '0;
            rot_o  <= 1'b0;
            shf_o  <= 1'b0;
        end else begin
            rot_o <= 1'b0;
            shf_o <= 1'b0;
            if (clear_i) begin
                idx_o  <= '0;
                used_o <= '0;
            end else if (step_i) begin
                unique case (act_i)
                    ACT_ADD: begin
                        idx_o  <= idx_o + rd_data_i;
                        used_o <= used_o | hi_bit;
                        shf_o  <= 1'b1;
                    end
                    ACT_DBL_ADD: begin
                        idx_o <= (idx_o << 1) + rd_data_i;
                        rot_o <= 1'b1;
                        shf_o <= 1'b1;
                    end
                    ACT_DBL: begin
                        idx_o <= idx_o << 1;
                        rot_o <= 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

    // R4: a repeat is only ever decided for a register already in the set
    a_r4_repeat_was_used: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && act_i == ACT_DBL_ADD) |-> ((used_o & hi_bit) != '0));

    // R5: a base-digit doubling leaves the used set unchanged
    a_r5_used_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && act_i == ACT_DBL) |=> $stable(used_o));
endmodule

// File: rtl/pva_disp_acc.sv
// Packed BCD displacement shift register and its binary value.
// Assumes DW is a multiple of 4; the oldest digit is dropped on overflow.
module pva_disp_acc #(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step_i,
    input  logic          clear_i,
    input  logic [3:0]    digit_i,
    output logic [DW-1:0] disp_o,
    output logic [AW-1:0] bin_o
);
    localparam int NDIG = DW / 4;

    // Shift in one digit per prefix, clear at the end of a vector.
    always_ff @(posedge clk) begin
        if (!rst_n)       disp_o <= '0;
        else if (clear_i) disp_o <= '0;
        else if (step_i)  disp_o <= {disp_o[DW-5:0], digit_i};
    end

    // Decimal to binary, most significant digit first, modulo 2^AW.
    always_comb begin
        bin_o = '0;
        for (int i = NDIG - 1; i >= 0; i--) begin
            bin_o = (bin_o << 3) + (bin_o << 1) + AW'(disp_o[i*4 +: 4]);
        end
    end

    // R2: the newest digit lands in the least significant nibble
    a_r2_low_digit: assert property (@(posedge clk) disable iff (!rst_n)
        step_i |=> (disp_o[3:0] == $past(digit_i)));
endmodule

// File: rtl/prefix_vector_agu.sv
// Top of the prefix vector address calculator.
// Accepts prefix bytes, reads registers through a combinational port,
// and produces base + weighted index + decimal displacement on a terminator.
// Assumes register values stay stable while a vector is being built.
module prefix_vector_agu
    import pva_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mode_n,
    input  logic          en_n,
    input  logic          base_le_n,
    input  logic [7:0]    pfx_i,
    output logic [3:0]    rd_idx_o,
    input  logic [AW-1:0] rd_data_i,
    output logic [3:0]    base_idx_o,
    output logic          rotate_o,
    output logic          shift_o,
    output logic          addr_valid_o,
    output logic [AW-1:0] addr_o,
    output logic [DW-1:0] disp_bcd_o
);
    logic            active_q;
    logic [3:0]      base_q;
    logic [AW-1:0]   bval_q;
    logic            term;
    pva_act_e        act;
    logic [AW-1:0]   idx;
    logic [NREG-1:0] used;
    logic [DW-1:0]   disp;
    logic [AW-1:0]   disp_bin;
    logic            take, pfx_step, term_hit, abandon, clear;

    // Decode the control inputs into step and clear events.
    always_comb begin
        take     = !en_n && !mode_n;
        pfx_step = take && !term;
        term_hit = take && term;
        abandon  = !en_n && mode_n;
        clear    = term_hit || abandon;
        rd_idx_o = pfx_i[7:4];
    end

    pva_classify i_classify (
        .byte_i   (pfx_i),
        .active_i (active_q),
        .base_i   (base_q),
        .used_i   (used),
        .term_o   (term),
        .act_o    (act)
    );

    pva_index_acc #(.AW(AW)) i_index (
        .clk       (clk),
        .rst_n     (rst_n),
        .step_i    (pfx_step),
        .clear_i   (clear),
        .act_i     (act),
        .hi_i      (pfx_i[7:4]),
        .rd_data_i (rd_data_i),
        .idx_o     (idx),
        .used_o    (used),
        .rot_o     (rotate_o),
        .shf_o     (shift_o)
    );

    pva_disp_acc #(.AW(AW), .DW(DW)) i_disp (
        .clk     (clk),
        .rst_n   (rst_n),
        .step_i  (pfx_step),
        .clear_i (clear),
        .digit_i (pfx_i[3:0]),
        .disp_o  (disp),
        .bin_o   (disp_bin)
    );

    // Track the open vector and capture the base register and its value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            base_q   <= '0;
            bval_q   <= '0;
        end else if (clear) begin
            active_q <= 1'b0;
            base_q   <= '0;
            bval_q   <= '0;
        end else if (pfx_step && !active_q) begin
            active_q <= 1'b1;
            base_q   <= pfx_i[7:4];
            bval_q   <= rd_data_i;
        end
    end

    // Latch the base index output when enabled on a first prefix.
    always_ff @(posedge clk) begin
        if (!rst_n)
            base_idx_o <= '0;
        else if (pfx_step && !active_q && !base_le_n)
            base_idx_o <= pfx_i[7:4];
    end

    // Present the finished address for one cycle after a terminator.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_valid_o <= 1'b0;
            addr_o       <= '0;
            disp_bcd_o   <= '0;
        end else begin
            addr_valid_o <= term_hit && active_q;
            if (term_hit && active_q) begin
                addr_o     <= bval_q + idx + disp_bin;
                disp_bcd_o <= disp;
            end
        end
    end

    // R6: the valid pulse lasts one cycle
    a_r6_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
        addr_valid_o |=> !addr_valid_o);

    // R6: the vector state is gone when the address is shown
    a_r6_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        addr_valid_o |-> (!active_q && used == '0));

    // R1: a first prefix fires no strobe
    a_r1_first_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (pfx_step && !active_q) |=> (!rotate_o && !shift_o));

    // R8: an idle cycle changes no output pulse
    a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        en_n |=> (!rotate_o && !shift_o && !addr_valid_o));

    // R9: an abandon produces no pulse
    a_r9_abandon_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        abandon |=> (!rotate_o && !shift_o && !addr_valid_o));
endmodule

// File: tb/test_prefix_vector_agu.sv
`timescale 1ns/1ps
module test_prefix_vector_agu;
    localparam int AW = 32;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          mode_n = 1'b1;
    logic          en_n = 1'b1;
    logic          base_le_n = 1'b1;
    logic [7:0]    pfx = 8'h00;
    logic [3:0]    rd_idx;
    logic [AW-1:0] rd_data;
    logic [3:0]    base_idx;
    logic          rot, shf, vld;
    logic [AW-1:0] addr;
    logic [DW-1:0] disp;
    logic [AW-1:0] regs [16];

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    // reference state
    bit            m_active;
    logic [3:0]    m_base, m_bidx;
    logic [AW-1:0] m_bval, m_idx, e_addr;
    logic [9:0]    m_used;
    logic [DW-1:0] m_disp, e_disp;
    bit            e_rot, e_shf, e_vld;
    string         e_tag;

    always #2.5 clk = ~clk;
    assign rd_data = regs[rd_idx];

    prefix_vector_agu #(.AW(AW), .DW(DW)) i_prefix_vector_agu (
        .clk(clk), .rst_n(rst_n), .mode_n(mode_n), .en_n(en_n),
        .base_le_n(base_le_n), .pfx_i(pfx), .rd_idx_o(rd_idx),
        .rd_data_i(rd_data), .base_idx_o(base_idx), .rotate_o(rot),
        .shift_o(shf), .addr_valid_o(vld), .addr_o(addr), .disp_bcd_o(disp)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [AW-1:0] bcd_value(input logic [DW-1:0] d);
        logic [AW-1:0] v = '0;
        for (int i = DW/4 - 1; i >= 0; i--) v = v * 10 + AW'(d[i*4 +: 4]);
        return v;
    endfunction

    task automatic m_clear();
        m_active = 0; m_idx = '0; m_used = '0; m_disp = '0; m_base = '0; m_bval = '0;
    endtask

    // Advance the reference for one byte and set the expected outputs.
    task automatic m_step(input logic [7:0] b, input bit en_v, input bit mode_v, input bit le_v);
        logic [3:0] hi = b[7:4];
        logic [3:0] lo = b[3:0];
        e_rot = 0; e_shf = 0; e_vld = 0;
        if (en_v) begin
            e_tag = "R8";
        end else if (mode_v) begin
            e_tag = "R9"; m_clear();
        end else if (b == 8'h00 || hi > 9 || lo > 9) begin
            if (m_active) begin
                e_tag = "R6"; e_vld = 1;
                e_addr = m_bval + m_idx + bcd_value(m_disp);
                e_disp = m_disp;
            end else e_tag = "R7";
            m_clear();
        end else begin
            if (!m_active) begin
                e_tag = "R1"; m_active = 1; m_base = hi; m_bval = regs[hi];
                if (!le_v) m_bidx = hi;
            end else if (hi == m_base) begin
                e_tag = "R5"; m_idx = m_idx << 1; e_rot = 1;
            end else if (m_used[hi]) begin
                e_tag = "R4"; m_idx = (m_idx << 1) + regs[hi]; e_rot = 1; e_shf = 1;
            end else begin
                e_tag = "R3"; m_idx = m_idx + regs[hi]; m_used[hi] = 1'b1; e_shf = 1;
            end
            m_disp = {m_disp[DW-5:0], lo};
        end
    endtask

    // Drive one byte from a falling edge, then check after the next rising edge.
    task automatic send(input logic [7:0] b, input bit en_v, input bit mode_v, input bit le_v);
        pfx = b; en_n = en_v; mode_n = mode_v; base_le_n = le_v;
        m_step(b, en_v, mode_v, le_v);
        @(negedge clk);
        check({e_tag, " strobes/valid"}, {rot, shf, vld}, {e_rot, e_shf, e_vld});
        check("R10 base index", base_idx, m_bidx);
        if (e_vld) begin
            check("R6 address", addr, e_addr);
            check("R2 displacement", disp, e_disp);
        end
    endtask

    task automatic pfx_send(input logic [7:0] b);
        send(b, 1'b0, 1'b0, 1'b0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        for (int i = 0; i < 16; i++) regs[i] = 32'(i * 1000 + i);
        m_clear(); m_bidx = '0;
        repeat (3) @(negedge clk);
        // R11: reset state
        check("R11 reset", {base_idx, rot, shf, vld, addr, disp}, '0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3 R4 R5 R6: worked example, base D1, 14*D2+4*D6+2*D8, disp 2345790
        foreach (sample_stream[k]) pfx_send(sample_stream[k]);
        check("R6 example address", addr, 32'd2414859);
        check("R2 example displacement", disp, 32'h02345790);

        // R4 R5: nested repeat 2*(2*D3+D6)+D6 with base D1
        pfx_send(8'h12); pfx_send(8'h34); pfx_send(8'h15);
        pfx_send(8'h67); pfx_send(8'h68); pfx_send(8'hF0);
        check("R4 nested address", addr, 32'd55609);

        // R7: terminator with nothing open
        pfx_send(8'h00);
        pfx_send(8'h9A);
        // R9: abandon mid-vector, then terminator gives nothing
        pfx_send(8'h45); pfx_send(8'h67);
        send(8'h11, 1'b0, 1'b1, 1'b0);
        pfx_send(8'hAA);
        // R10: base latch disabled on first prefix
        send(8'h73, 1'b0, 1'b0, 1'b1);
        // R8: idle bytes ignored, then the vector still closes correctly
        send(8'h55, 1'b1, 1'b0, 1'b0);
        send(8'h00, 1'b1, 1'b1, 1'b0);
        pfx_send(8'h21); pfx_send(8'h0B);

        // random vectors, some longer than eight digits (R2 wrap)
        for (int v = 0; v < 400; v++) begin
            int n = 1 + ($urandom % 12);
            for (int i = 0; i < 10; i++) regs[i] = $urandom;
            for (int i = 0; i < n; i++) begin
                logic [7:0] b;
                b[7:4] = 4'($urandom % 10);
                b[3:0] = 4'($urandom % 10);
                if (b == 8'h00) b[3:0] = 4'd1;
                if (($urandom % 8) == 0) send(8'($urandom), 1'b1, 1'($urandom), 1'b0);
                send(b, 1'b0, 1'b0, 1'($urandom % 4 == 0));
            end
            case ($urandom % 3)
                0: pfx_send(8'h00);
                1: pfx_send({4'hA + 4'($urandom % 6), 4'($urandom)});
                default: pfx_send({4'($urandom % 10), 4'hA + 4'($urandom % 6)});
            endcase
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    logic [7:0] sample_stream [8] = '{8'h12, 8'h23, 8'h24, 8'h65, 8'h27, 8'h89, 8'h10, 8'h00};
endmodule